// File: doc/BRIEF.md
# External bus access cycle stretcher

This block works out, for each instruction, how many extra cycles the pipeline must be held so that the instruction's off-chip traffic fits on the one external bus. Three memory requests come with every instruction: a program fetch, a primary X data access and a secondary X data access. Each has a request flag and a flag that marks it external. Two programmable 4-bit wait-state counts, one for single moves and one for program-memory moves, set the cost of an external access. The block adds nothing while all traffic stays on-chip. It adds the relevant wait-state count when one access goes external. When both the fetch and the primary data access are external, the two go out in turn on the bus, so the block adds a full extra cycle plus both wait-state counts.

When an instruction starts, the block samples its inputs and records the cost of the instruction. It then holds a stall line to the pipeline for exactly that many cycles and reports the order in which the external bus cycles run. The secondary data access may only target on-chip memory. If that access is marked external, the block raises an error flag and gives it no cycles.

Top module: `ext_stretch`

## Requirements
- R1: With every requested access on-chip, the instruction adds 0 extra cycles and stall_o stays low.
- R2: An external program fetch with on-chip data accesses adds exactly mvm_ws_i cycles.
- R3: An external primary X access with an on-chip program fetch adds exactly mv_ws_i cycles.
- R4: When the program fetch and the primary X access are both external, the instruction adds 1 + mv_ws_i + mvm_ws_i cycles.
- R5: A requested secondary X access marked external sets err_o high for that instruction and adds 0 cycles. The next instruction without such an access clears err_o.
- R6: Bus order codes are 0 = none, 1 = program fetch, 2 = data access. With both external, bus_first_o = 2 and bus_second_o = 1. With one external, bus_first_o names that access and bus_second_o = 0. With none external, both are 0.
- R7: stall_o is high for exactly ext_cycles_o consecutive cycles, starting in the cycle after start_i is taken, and ext_cycles_o holds the cost of the current instruction.
- R8: The wait-state counts are sampled only when start_i is taken. Changes during the stall do not alter its length.
- R9: start_i is ignored while stall_o is high. The stall length, ext_cycles_o, the bus order and err_o are not affected.
- R10: An external qualifier whose request flag is low is ignored, and that access counts as absent.
- R11: After reset, stall_o and err_o are low, ext_cycles_o is 0 and both bus order outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Instruction start strobe |
| pf_req_i | input | 1 | Program fetch requested |
| pf_ext_i | input | 1 | Program fetch targets external memory |
| x1_req_i | input | 1 | Primary X access requested |
| x1_ext_i | input | 1 | Primary X access targets external memory |
| x2_req_i | input | 1 | Secondary X access requested |
| x2_ext_i | input | 1 | Secondary X access marked external (illegal) |
| mv_ws_i | input | 4 | Wait states for single move accesses |
| mvm_ws_i | input | 4 | Wait states for program-memory move accesses |
| stall_o | output | 1 | Holds the pipeline |
| ext_cycles_o | output | 6 | Extra cycles of the current instruction |
| bus_first_o | output | 2 | First external bus cycle (0 none, 1 fetch, 2 data) |
| bus_second_o | output | 2 | Second external bus cycle |
| err_o | output | 1 | Secondary X access was marked external |

## Verification
The cost is tried with each on-chip/external mix of fetch and primary access, using unequal wait-state values such as 3 and 5. These values show whether the right count was picked and whether the extra cycle for the serialized case is present. Zero wait states separate the one-cycle serial penalty from the wait-state terms. Maximum values of 15 check the widest sum. Instructions with external qualifiers but no requests, and with an illegal secondary access, show that qualifiers are gated and that the error path costs nothing. Changing the wait states and pulsing start during a stall shows that values are sampled only at instruction start.

// File: rtl/xstr_pkg.sv
package xstr_pkg;
  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_PROG = 2'd1,
    BUS_DATA = 2'd2
  } bus_op_e;
endpackage

// File: rtl/xstr_cost.sv
module xstr_cost
  import xstr_pkg::*;
#(
  parameter int WS_W  = 4,
  parameter int CNT_W = WS_W + 2
) (
  input  logic             pf_ext_i,
  input  logic             x1_ext_i,
  input  logic             x2_ext_i,
  input  logic [WS_W-1:0]  mv_ws_i,
  input  logic [WS_W-1:0]  mvm_ws_i,
  output logic [CNT_W-1:0] cost_o,
  output logic [1:0]       first_o,
  output logic [1:0]       second_o,
  output logic             err_o
);
  logic [CNT_W-1:0] mv_w, mvm_w;
  assign mv_w  = CNT_W'(mv_ws_i);
  assign mvm_w = CNT_W'(mvm_ws_i);

  always_comb begin
    cost_o   = '0;
    first_o  = BUS_NONE;
    second_o = BUS_NONE;
    unique case ({pf_ext_i, x1_ext_i})
      2'b10: begin
        cost_o  = mvm_w;
        first_o = BUS_PROG;
      end
      2'b01: begin
        cost_o  = mv_w;
        first_o = BUS_DATA;
      end
      2'b11: begin
        // one bus: serialize, data before fetch
        cost_o   = CNT_W'(1) + mv_w + mvm_w;
        first_o  = BUS_DATA;
        second_o = BUS_PROG;
      end
      default: ;
    endcase
  end

  // secondary access never costs cycles, only flags
  assign err_o = x2_ext_i;
endmodule

// File: rtl/xstr_stall.sv
module xstr_stall #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             stall_o
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rem_q <= '0;
    else if (load_i)       rem_q <= load_val_i;
    else if (rem_q != '0)  rem_q <= rem_q - 1'b1;
  end

  assign stall_o = (rem_q != '0);

  // R7
  stall_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !load_i) |=> (rem_q == $past(rem_q) - 1'b1));

  // R7
  load_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (rem_q == $past(load_val_i)));
endmodule

// File: rtl/ext_stretch.sv
module ext_stretch
  import xstr_pkg::*;
#(
  parameter int WS_W  = 4,
  parameter int CNT_W = WS_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pf_req_i,
  input  logic             pf_ext_i,
  input  logic             x1_req_i,
  input  logic             x1_ext_i,
  input  logic             x2_req_i,
  input  logic             x2_ext_i,
  input  logic [WS_W-1:0]  mv_ws_i,
  input  logic [WS_W-1:0]  mvm_ws_i,
  output logic             stall_o,
  output logic [CNT_W-1:0] ext_cycles_o,
  output logic [1:0]       bus_first_o,
  output logic [1:0]       bus_second_o,
  output logic             err_o
);
  logic             pf_x, x1_x, x2_x, take;
  logic [CNT_W-1:0] cost;
  logic [1:0]       first_d, second_d;
  logic             err_d;

  // qualifiers only count with a live request
  assign pf_x = pf_req_i & pf_ext_i;
  assign x1_x = x1_req_i & x1_ext_i;
  assign x2_x = x2_req_i & x2_ext_i;
  assign take = start_i & ~stall_o;

  xstr_cost #(.WS_W(WS_W), .CNT_W(CNT_W)) u_cost (
    .pf_ext_i (pf_x),
    .x1_ext_i (x1_x),
    .x2_ext_i (x2_x),
    .mv_ws_i  (mv_ws_i),
    .mvm_ws_i (mvm_ws_i),
    .cost_o   (cost),
    .first_o  (first_d),
    .second_o (second_d),
    .err_o    (err_d)
  );

  xstr_stall #(.CNT_W(CNT_W)) u_stall (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (take),
    .load_val_i (cost),
    .stall_o    (stall_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_cycles_o <= '0;
      bus_first_o  <= BUS_NONE;
      bus_second_o <= BUS_NONE;
      err_o        <= 1'b0;
    end else if (take) begin
      ext_cycles_o <= cost;
      bus_first_o  <= first_d;
      bus_second_o <= second_d;
      err_o        <= err_d;
    end
  end

  // R1
  on_chip_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !pf_x && !x1_x) |=> !stall_o);

  // R6
  bus_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && pf_x && x1_x) |=> (bus_first_o == BUS_DATA && bus_second_o == BUS_PROG));

  // R5
  x2_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && x2_x && !pf_x && !x1_x) |=> (err_o && !stall_o));

  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && start_i) |=> ($stable(ext_cycles_o) && $stable(bus_first_o) && $stable(err_o)));

  // R4
  serial_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && pf_x && x1_x) |=> stall_o);
endmodule

// File: tb/ext_stretch_tb.sv
module ext_stretch_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       pf_r = 0, pf_e = 0, x1_r = 0, x1_e = 0, x2_r = 0, x2_e = 0;
  logic [3:0] mv = '0, mvm = '0;
  logic       stall, err;
  logic [5:0] ext_cycles;
  logic [1:0] b_first, b_second;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_stretch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .pf_req_i(pf_r), .pf_ext_i(pf_e), .x1_req_i(x1_r), .x1_ext_i(x1_e),
    .x2_req_i(x2_r), .x2_ext_i(x2_e), .mv_ws_i(mv), .mvm_ws_i(mvm),
    .stall_o(stall), .ext_cycles_o(ext_cycles), .bus_first_o(b_first),
    .bus_second_o(b_second), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pulse one instruction; returns the count of stalled cycles
  task automatic issue(input bit pr, pe, xr, xe, yr, ye, input int w_mv, w_mvm,
                       input bit poke, output int n);
    @(negedge clk);
    {pf_r, pf_e, x1_r, x1_e, x2_r, x2_e} = {pr, pe, xr, xe, yr, ye};
    mv = 4'(w_mv); mvm = 4'(w_mvm);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (stall && n < 64) begin
      if (poke) begin
        mv = 4'd15; mvm = 4'd15;
        {pf_r, pf_e, x1_r, x1_e, x2_r, x2_e} = 6'b111111;
        start = 1'b1;
      end
      n++;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk(!stall, "R11 stall", stall, 0);
    chk(!err, "R11 err", err, 0);
    chk(ext_cycles == 0, "R11 cycles", ext_cycles, 0);
    chk(b_first == 0 && b_second == 0, "R11 order", {b_first, b_second}, 0);
  endtask

  task automatic t_onchip();
    int n;
    issue(1, 0, 1, 0, 1, 0, 7, 9, 0, n);
    chk(n == 0, "R1 stall len", n, 0);
    chk(ext_cycles == 0, "R1 cycles", ext_cycles, 0);
    chk(b_first == 0 && b_second == 0, "R6 none", {b_first, b_second}, 0);
  endtask

  task automatic t_ext_fetch();
    int n;
    issue(1, 1, 1, 0, 0, 0, 3, 5, 0, n);
    chk(n == 5, "R2 stall len", n, 5);
    chk(ext_cycles == 5, "R7 cycles", ext_cycles, 5);
    chk(b_first == 1 && b_second == 0, "R6 fetch only", {b_first, b_second}, 4);
  endtask

  task automatic t_ext_data();
    int n;
    issue(1, 0, 1, 1, 1, 0, 3, 5, 0, n);
    chk(n == 3, "R3 stall len", n, 3);
    chk(b_first == 2 && b_second == 0, "R6 data only", {b_first, b_second}, 8);
  endtask

  task automatic t_serial();
    int n;
    issue(1, 1, 1, 1, 0, 0, 3, 5, 0, n);
    chk(n == 9, "R4 stall len", n, 9);
    chk(ext_cycles == 9, "R7 cycles", ext_cycles, 9);
    chk(b_first == 2 && b_second == 1, "R6 both", {b_first, b_second}, 9);
    issue(1, 1, 1, 1, 0, 0, 0, 0, 0, n);
    chk(n == 1, "R4 zero ws", n, 1);
    issue(1, 1, 1, 1, 0, 0, 15, 15, 0, n);
    chk(n == 31, "R4 max ws", n, 31);
  endtask

  task automatic t_x2_err();
    int n;
    issue(1, 0, 1, 0, 1, 1, 4, 4, 0, n);
    chk(err, "R5 err set", err, 1);
    chk(n == 0, "R5 no cost", n, 0);
    issue(1, 1, 0, 0, 1, 1, 4, 6, 0, n);
    chk(err && n == 6, "R5 err with fetch", n, 6);
    issue(1, 0, 1, 0, 1, 0, 4, 4, 0, n);
    chk(!err, "R5 err clear", err, 0);
  endtask

  task automatic t_unreq();
    int n;
    issue(0, 1, 0, 1, 0, 1, 6, 6, 0, n);
    chk(n == 0, "R10 stall len", n, 0);
    chk(!err, "R10 err", err, 0);
    chk(b_first == 0, "R10 order", b_first, 0);
  endtask

  task automatic t_sample_busy();
    int n;
    issue(1, 1, 0, 0, 0, 0, 2, 4, 1, n);
    chk(n == 4, "R8 R9 stall len", n, 4);
    chk(ext_cycles == 4, "R9 cycles", ext_cycles, 4);
    chk(b_first == 1 && b_second == 0, "R9 order", {b_first, b_second}, 4);
    chk(!err, "R9 err", err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_onchip();
    t_ext_fetch();
    t_ext_data();
    t_serial();
    t_x2_err();
    t_unreq();
    t_sample_busy();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule